// File: doc/BRIEF.md
# Registered Four-Bit Function-Select ALU

This block is a four-bit arithmetic and logic unit that takes two operands, a four-bit function code, a mode bit and an active-low carry input. Together these choose one of sixteen bitwise logic functions or one of sixteen arithmetic functions. In arithmetic mode every function is the sum of two derived four-bit terms plus the carry. The carries into the four bit positions come from flat lookahead equations, so no carry passes from one bit position to the next.

All inputs are captured in a register stage at the first clock edge. The result, the active-low carry out, the active-low group propagate and generate signals, and the all-ones flag are captured in a second register stage. A new operation can be applied on every cycle, and each result appears two edges after its operands. A synchronous active-high reset clears both register stages.

Top module: `alu181_top`

## Requirements
- R1: While `rst` is high at a rising edge, every output register is cleared, so `f_out`, `cout_n`, `prop_n`, `gen_n` and `eq_out` all read 0 after that edge.
- R2: Inputs applied before rising edge k appear on the outputs after rising edge k+1. After edge k alone, the outputs still show the previous operation.
- R3: With `mode`=1 (logic), `f_out` depends only on the operand bits at the same position, and `cin_n` has no effect on it. The codes `sel[3:0]` map as follows. 1111 gives A and 1010 gives B. 0000 gives NOT A and 0101 gives NOT B. 0110 gives A XOR B and 1001 gives XNOR. 1011 gives AND, 1110 gives OR, 0100 gives NAND and 0001 gives NOR. 0111 gives A AND NOT B and 0010 gives NOT A AND B. 1101 gives A OR NOT B and 1000 gives NOT A OR B. 0011 gives all zeros and 1100 gives all ones.
- R4: With `mode`=0 and `cin_n`=1, `f_out` is the low four bits of first term plus second term, with the bit-4 carry dropped. The terms are: 0000 A,0; 0001 A|B,0; 0010 A|~B,0; 0011 1111,0; 0100 A,A&~B; 0101 A|B,A&~B; 0110 A,~B; 0111 A&~B,1111; 1000 A,A&B; 1001 A,B; 1010 A|~B,A&B; 1011 A&B,1111; 1100 A,A; 1101 A|B,A; 1110 A|~B,A; 1111 A,1111.
- R5: With `mode`=0 and `cin_n`=0, every arithmetic result is one larger, modulo 16, than with `cin_n`=1.
- R6: `cout_n` is 0 exactly when first term + second term + (NOT `cin_n`) reaches 16. This holds for the code's terms in either mode.
- R7: `prop_n` is 0 exactly when (first term OR second term) of the selected code is 1111. It does not depend on `mode` or `cin_n`.
- R8: `gen_n` is 0 exactly when first term + second term reaches 16 with no carry in. When `gen_n` is 0, `cout_n` is also 0.
- R9: `eq_out` is 1 exactly when `f_out` is 1111, in either mode.
- R10: Operations applied on consecutive cycles produce their results on consecutive cycles, each two edges after its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 4 | Operand A |
| b_in | input | 4 | Operand B |
| sel | input | 4 | Function code S3..S0 |
| mode | input | 1 | 1 = logic, 0 = arithmetic |
| cin_n | input | 1 | Carry input, active low |
| f_out | output | 4 | Registered result |
| cout_n | output | 1 | Registered carry out, active low |
| prop_n | output | 1 | Registered group propagate, active low |
| gen_n | output | 1 | Registered group generate, active low |
| eq_out | output | 1 | Registered all-ones flag |

## Verification
The bench sweeps all 32 functions under both carry values. It includes the cases where the carry polarity is easy to invert: A minus 1 on a zero operand and A minus B minus 1 with equal operands. These show whether `cout_n` or `eq_out` has the wrong sense, or whether the carry leaks into logic mode. It drives cases where the group generate fires without any carry in, and where only the propagate chain carries an incoming carry. A swapped lookahead term shows up as a wrong `gen_n`/`prop_n` pairing. Back-to-back random operations and a one-edge latency probe catch a missing or doubled register stage. A reset applied in the middle of a run catches registers that are left uncleared.

// File: rtl/alu181_pkg.sv
package alu181_pkg;

    localparam int SEL_W = 4;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             mode;
        logic             cin_n;
    } alu_ctl_t;

    typedef struct packed {
        logic eq;
        logic gen_n;
        logic prop_n;
        logic cout_n;
    } alu_flags_t;

endpackage

// File: rtl/alu181_terms.sv
module alu181_terms #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   sel,
    output logic [W-1:0] term_x,
    output logic [W-1:0] term_y
);
    // Per-bit term formation: term_x is the OR-style operand, term_y the
    // AND-style operand; term_y is always a subset of term_x.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign term_x[i] = a[i] | (sel[0] & b[i]) | (sel[1] & ~b[i]);
        assign term_y[i] = (sel[3] & a[i] & b[i]) | (sel[2] & a[i] & ~b[i]);
    end
endmodule

// File: rtl/alu181_cla.sv
module alu181_cla #(
    parameter int W = 4
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] g,
    input  logic         c0,
    output logic [W:0]   carry,
    output logic         grp_p,
    output logic         grp_g
);
    logic [W:1] gen_v;
    logic [W:1] prop_v;

    assign carry[0] = c0;

    // Each carry is an independent sum of products of the bit terms.
    for (genvar i = 1; i <= W; i++) begin : g_carry
        always_comb begin
            gen_v[i]  = 1'b0;
            prop_v[i] = 1'b1;
            for (int j = i - 1; j >= 0; j--) begin
                gen_v[i]  = gen_v[i] | (g[j] & prop_v[i]);
                prop_v[i] = prop_v[i] & p[j];
            end
        end
        assign carry[i] = gen_v[i] | (prop_v[i] & c0);
    end

    assign grp_p = prop_v[W];
    assign grp_g = gen_v[W];
endmodule

// File: rtl/alu181_result.sv
module alu181_result #(
    parameter int W = 4
) (
    input  logic [W-1:0] term_x,
    input  logic [W-1:0] term_y,
    input  logic [W-1:0] carry,
    input  logic         logic_mode,
    output logic [W-1:0] f,
    output logic         all_ones
);
    logic [W-1:0] half;

    assign half = term_x ^ term_y;

    always_comb begin
        if (logic_mode) begin
            f = ~half;
        end else begin
            f = half ^ carry;
        end
    end

    assign all_ones = &f;
endmodule

// File: rtl/alu181_top.sv
module alu181_top
    import alu181_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [3:0]   sel,
    input  logic         mode,
    input  logic         cin_n,
    output logic [W-1:0] f_out,
    output logic         cout_n,
    output logic         prop_n,
    output logic         gen_n,
    output logic         eq_out
);
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    alu_ctl_t     ctl_q;
    alu_flags_t   flags_q;
    alu_flags_t   flags_d;

    logic [W-1:0] term_x;
    logic [W-1:0] term_y;
    logic [W:0]   carry;
    logic         grp_p;
    logic         grp_g;
    logic [W-1:0] f_d;
    logic         eq_d;

    // Input register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            ctl_q <= '0;
        end else begin
            a_q   <= a_in;
            b_q   <= b_in;
            ctl_q <= '{sel: sel, mode: mode, cin_n: cin_n};
        end
    end

    alu181_terms #(.W(W)) u_terms (
        .a      (a_q),
        .b      (b_q),
        .sel    (ctl_q.sel),
        .term_x (term_x),
        .term_y (term_y)
    );

    alu181_cla #(.W(W)) u_cla (
        .p     (term_x | term_y),
        .g     (term_x & term_y),
        .c0    (~ctl_q.cin_n),
        .carry (carry),
        .grp_p (grp_p),
        .grp_g (grp_g)
    );

    alu181_result #(.W(W)) u_result (
        .term_x     (term_x),
        .term_y     (term_y),
        .carry      (carry[W-1:0]),
        .logic_mode (ctl_q.mode),
        .f          (f_d),
        .all_ones   (eq_d)
    );

    always_comb begin
        flags_d.eq     = eq_d;
        flags_d.gen_n  = ~grp_g;
        flags_d.prop_n = ~grp_p;
        flags_d.cout_n = ~carry[W];
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            f_out   <= '0;
            flags_q <= '0;
        end else begin
            f_out   <= f_d;
            flags_q <= flags_d;
        end
    end

    assign cout_n = flags_q.cout_n;
    assign prop_n = flags_q.prop_n;
    assign gen_n  = flags_q.gen_n;
    assign eq_out = flags_q.eq;
endmodule

// File: rtl/alu181_chk.sv
module alu181_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [3:0]   sel,
    input logic         mode,
    input logic         cin_n,
    input logic [W-1:0] f_out,
    input logic         cout_n,
    input logic         prop_n,
    input logic         gen_n,
    input logic         eq_out
);
    logic [1:0] run_cnt;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            run_cnt <= 2'd0;
        end else if (run_cnt != 2'd3) begin
            run_cnt <= run_cnt + 2'd1;
        end
    end

    // R1
    always @(posedge clk) begin
        if (rst_q) begin
            reset_clear_chk: assert (f_out == '0 && !cout_n && !prop_n && !gen_n && !eq_out)
                else $error("outputs not cleared by reset");
        end
    end

    // R3
    logic_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd2 && $past(mode, 2) && $past(sel, 2) == 4'hF)
        |-> f_out == $past(a_in, 2));

    // R4
    add_path_chk: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd2 && !$past(mode, 2) && $past(sel, 2) == 4'h9)
        |-> {~cout_n, f_out} == ({1'b0, $past(a_in, 2)} + {1'b0, $past(b_in, 2)}
                                  + {{W{1'b0}}, ~$past(cin_n, 2)}));

    // R8
    gen_forces_carry_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_n |-> !cout_n);

    // R7
    prop_passes_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd2 && !prop_n && !$past(cin_n, 2)) |-> !cout_n);

    // R9
    eq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        eq_out == (f_out == {W{1'b1}}));
endmodule

bind alu181_top alu181_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .a_in   (a_in),
    .b_in   (b_in),
    .sel    (sel),
    .mode   (mode),
    .cin_n  (cin_n),
    .f_out  (f_out),
    .cout_n (cout_n),
    .prop_n (prop_n),
    .gen_n  (gen_n),
    .eq_out (eq_out)
);

// File: tb/tb_alu181_top.sv
`timescale 1ns/1ps
module tb_alu181_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] a_in, b_in, sel;
    logic       mode, cin_n;
    logic [3:0] f_out;
    logic       cout_n, prop_n, gen_n, eq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    alu181_top dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .sel(sel),
        .mode(mode), .cin_n(cin_n), .f_out(f_out), .cout_n(cout_n),
        .prop_n(prop_n), .gen_n(gen_n), .eq_out(eq_out)
    );

    always #5 clk = ~clk;

    // Expected {eq, gen_n, prop_n, cout_n, f} from the function map.
    function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b,
                                         input logic [3:0] s, input logic m,
                                         input logic cn_n);
        logic [3:0] x, y, lf, fr;
        logic [4:0] sum0, sum;
        case (s)
            4'h0: begin x = a;       y = 4'h0;    lf = ~a;       end
            4'h1: begin x = a | b;   y = 4'h0;    lf = ~(a | b); end
            4'h2: begin x = a | ~b;  y = 4'h0;    lf = ~a & b;   end
            4'h3: begin x = 4'hF;    y = 4'h0;    lf = 4'h0;     end
            4'h4: begin x = a;       y = a & ~b;  lf = ~(a & b); end
            4'h5: begin x = a | b;   y = a & ~b;  lf = ~b;       end
            4'h6: begin x = a;       y = ~b;      lf = a ^ b;    end
            4'h7: begin x = a & ~b;  y = 4'hF;    lf = a & ~b;   end
            4'h8: begin x = a;       y = a & b;   lf = ~a | b;   end
            4'h9: begin x = a;       y = b;       lf = ~(a ^ b); end
            4'hA: begin x = a | ~b;  y = a & b;   lf = b;        end
            4'hB: begin x = a & b;   y = 4'hF;    lf = a & b;    end
            4'hC: begin x = a;       y = a;       lf = 4'hF;     end
            4'hD: begin x = a | b;   y = a;       lf = a | ~b;   end
            4'hE: begin x = a | ~b;  y = a;       lf = a | b;    end
            default: begin x = a;    y = 4'hF;    lf = a;        end
        endcase
        sum0 = {1'b0, x} + {1'b0, y};
        sum  = sum0 + {4'b0, ~cn_n};
        fr   = m ? lf : sum[3:0];
        return {(fr == 4'hF), ~sum0[4], ~((x | y) == 4'hF), ~sum[4], fr};
    endfunction

    function automatic logic [7:0] observed();
        return {eq_out, gen_n, prop_n, cout_n, f_out};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got {eq,g_n,p_n,co_n,f}=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                         input logic m, input logic cn);
        a_in = a; b_in = b; sel = s; mode = m; cin_n = cn;
    endtask

    // Apply one operation and check after two rising edges.
    task automatic run_op(input string tag, input logic [3:0] a, input logic [3:0] b,
                          input logic [3:0] s, input logic m, input logic cn);
        drive(a, b, s, m, cn);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(tag, observed(), model(a, b, s, m, cn));
    endtask

    task automatic run_f(input string tag, input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] s, input logic m, input logic cn,
                         input logic [3:0] f_exp);
        drive(a, b, s, m, cn);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(tag, {4'h0, f_out}, {4'h0, f_exp});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(4'h0, 4'h0, 4'h0, 1'b0, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 power-up reset", observed(), 8'h00);
        rst = 1'b0;
        // mid-run reset after a nonzero result
        run_op("R1 pre-reset op", 4'hC, 4'h3, 4'hE, 1'b1, 1'b1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 reset mid-run", observed(), 8'h00);
        rst = 1'b0;
    endtask

    task automatic t_examples();
        run_f("R3 xor example", 4'b0000, 4'b0101, 4'b0110, 1'b1, 1'b1, 4'b0101);
        run_f("R4 a-b-1 example", 4'b0000, 4'b0101, 4'b0110, 1'b0, 1'b1, 4'b1010);
        run_f("R3 pass A", 4'b1010, 4'b1001, 4'b1111, 1'b1, 1'b1, 4'b1010);
        run_f("R3 pass B", 4'b1010, 4'b1001, 4'b1010, 1'b1, 1'b1, 4'b1001);
        run_f("R3 not B", 4'b1010, 4'b1001, 4'b0101, 1'b1, 1'b1, 4'b0110);
        run_f("R3 not A", 4'b1010, 4'b1001, 4'b0000, 1'b1, 1'b1, 4'b0101);
        run_f("R4 A minus 1", 4'b1010, 4'b1001, 4'b1111, 1'b0, 1'b1, 4'b1001);
        run_f("R4 code 1010", 4'b1010, 4'b1001, 4'b1010, 1'b0, 1'b1, 4'b0110);
        run_f("R4 code 0101", 4'b1010, 4'b1001, 4'b0101, 1'b0, 1'b1, 4'b1101);
        run_f("R4 transfer A", 4'b1010, 4'b1001, 4'b0000, 1'b0, 1'b1, 4'b1010);
        run_f("R5 A plus B plus 1", 4'b0111, 4'b0001, 4'b1001, 1'b0, 1'b0, 4'b1001);
    endtask

    task automatic t_logic_sweep();
        for (int s = 0; s < 16; s++) begin
            for (int cn = 0; cn < 2; cn++) begin
                run_op("R3 logic sweep", 4'b1010, 4'b1001, 4'(s), 1'b1, 1'(cn));
                run_op("R3 logic sweep", 4'b0011, 4'b0101, 4'(s), 1'b1, 1'(cn));
            end
        end
    endtask

    task automatic t_arith_sweep();
        for (int s = 0; s < 16; s++) begin
            for (int cn = 0; cn < 2; cn++) begin
                run_op("R4 R5 R6 arith sweep", 4'b1010, 4'b1001, 4'(s), 1'b0, 1'(cn));
                run_op("R4 R5 R6 arith sweep", 4'b0000, 4'b1111, 4'(s), 1'b0, 1'(cn));
                run_op("R4 R5 R6 arith sweep", 4'b1111, 4'b0110, 4'(s), 1'b0, 1'(cn));
            end
        end
    endtask

    task automatic t_flags();
        // all bits propagate, carry-in ripples out: 1111 + 0000 + 1
        drive(4'h0, 4'h5, 4'h3, 1'b0, 1'b0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R7 propagate low", {7'h0, prop_n}, 8'h00);
        check("R6 carry via propagate", {7'h0, cout_n}, 8'h00);
        check("R8 no generate", {7'h0, gen_n}, 8'h01);
        // A plus A with A=1000 generates out of bit 3
        drive(4'h8, 4'h0, 4'hC, 1'b0, 1'b1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R8 generate low", {7'h0, gen_n}, 8'h00);
        check("R6 carry from generate", {7'h0, cout_n}, 8'h00);
        // A minus B minus 1 with A=B gives 1111
        drive(4'h6, 4'h6, 4'h6, 1'b0, 1'b1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 equal flag set", {7'h0, eq_out}, 8'h01);
        check("R6 no carry when A=B", {7'h0, cout_n}, 8'h01);
        drive(4'h6, 4'h5, 4'h6, 1'b0, 1'b1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 equal flag clear", {7'h0, eq_out}, 8'h00);
    endtask

    task automatic t_latency();
        logic [7:0] first_exp, second_exp;
        first_exp  = model(4'h3, 4'h4, 4'h9, 1'b0, 1'b1);
        second_exp = model(4'hA, 4'h5, 4'hB, 1'b1, 1'b1);
        run_op("R2 first op", 4'h3, 4'h4, 4'h9, 1'b0, 1'b1);
        drive(4'hA, 4'h5, 4'hB, 1'b1, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R2 one edge keeps old", observed(), first_exp);
        @(posedge clk); @(negedge clk);
        check("R2 two edges give new", observed(), second_exp);
    endtask

    task automatic t_stream();
        logic [7:0] exp_d1, exp_d2;
        exp_d1 = '0;
        exp_d2 = '0;
        for (int k = 0; k < 152; k++) begin
            if (k >= 2) check("R10 back-to-back", observed(), exp_d2);
            exp_d2 = exp_d1;
            if (k < 150) begin
                for (int n = 0; n < 5; n++)
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                drive(lfsr[3:0], lfsr[7:4], lfsr[11:8], lfsr[12], lfsr[13]);
                exp_d1 = model(lfsr[3:0], lfsr[7:4], lfsr[11:8], lfsr[12], lfsr[13]);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_examples();
        t_logic_sweep();
        t_arith_sweep();
        t_flags();
        t_latency();
        t_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule